// File: doc/BRIEF.md
# Query Response Lane Replicator

This block forms the read word returned while a flash bank sits in query mode or identifier mode. The bank is built from one or more narrow flash devices laid side by side. From the bus address it derives a table index, fetches either one byte of the built-in query table or an identifier code, and copies the result into every byte lane and device lane, so that each device in the bank seems to answer for itself. A bus access wider than the bank is split into bank-wide slices. Each slice does its own lookup at an address one bank width further on, and the slices are packed upward from bit 0.

The bank width, device width and largest supported device width are runtime inputs given as log2 byte counts. A separate flat-mode input stands for a bank whose device width is unspecified. In that mode the index comes from the low address byte only, and identifier reads return byte pairs. The result is computed combinationally and captured by a single output register when the read strobe is high. The data-valid flag goes high in the following cycle.

Top module: `qlr_lane_replicator`

## Requirements
- R1: Outside flat mode the table index equals `rd_addr` shifted right by `bank_lg + maxdev_lg - dev_lg` bits. The `*_lg` inputs give each width as log2 of its byte count (0=1, 1=2, 2=4 bytes).
- R2: In query mode, an index of 0x52 or above returns zero for that slice.
- R3: Query table entries 0x10, 0x11 and 0x12 hold the ASCII bytes 0x51, 0x52, 0x59. Entry 0x2A holds the write-buffer size code: 0x08 when the bank is 1 byte wide and 0x0B otherwise.
- R4: In query mode, when `dev_lg` differs from `maxdev_lg`, the table byte is copied into every byte of the maximum device width. This is supported only with `dev_lg`=0. Any other such combination returns zero.
- R5: When the device is narrower than the bank, the low device-width part of the result is copied into every device lane of the bank. The slice result is then limited to the bank width.
- R6: With `id_mode`=1 outside flat mode, an index whose low 8 bits equal 0 returns parameter `ID_A`. Low bits equal to 1 return `ID_B`. Any other value returns zero. All of these pass through the lane copy of R5.
- R7: When the access is wider than the bank, slice k is looked up at `rd_addr + k*bank_bytes` and placed at bit `8*k*bank_bytes`.
- R8: With `flat_mode`=1 the index is `rd_addr[7:0] >> bank_lg` and no lane copying or slicing takes place. An identifier read returns `{ID_A[7:0],ID_B[7:0]}` at index 0, `{ID_C[7:0],ID_D[7:0]}` at index 1, and zero elsewhere.
- R9: Bytes of `rd_data` above the access width (`acc_lg`, log2 bytes) are zero. An access narrower than the bank returns the low bytes of the slice.
- R10: Reset clears `rd_data` and `rd_valid`. `rd_valid` is high exactly in the cycle after `rd_stb`. `rd_data` changes only after a strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rd_stb | input | 1 | Read strobe, captures the response |
| rd_addr | input | ADDR_W | Bus byte address |
| acc_lg | input | 2 | log2 of access width in bytes |
| id_mode | input | 1 | 1 = identifier mode, 0 = query mode |
| flat_mode | input | 1 | 1 = device width unspecified |
| bank_lg | input | 2 | log2 of bank width in bytes |
| dev_lg | input | 2 | log2 of device width in bytes |
| maxdev_lg | input | 2 | log2 of maximum device width in bytes |
| rd_data | output | 32 | Registered response word |
| rd_valid | output | 1 | High the cycle after a strobe |

## Verification
The bench builds the block with a 16-bit address and four identifier codes whose byte values are all different. Because of this, every lane copy, slice placement and byte pairing appears as a distinct pattern in the read word. Since the widths are runtime inputs, a single instance covers banks of 1, 2 and 4 bytes, devices narrower than their maximum width, and both the supported and unsupported cases of that mismatch. The chosen addresses sit at the query signature and the size-code entry, at the out-of-range index, and at an identifier index whose bits above the low byte are set.

// File: rtl/qlr_pkg.sv
// Shared constants and helpers for the query response lane replicator.
// Assumes a 32-bit bus and width codes given as log2 of a byte count.
package qlr_pkg;

    localparam int BUS_BYTES = 4;
    localparam int BUS_W     = 8 * BUS_BYTES;
    localparam int TBL_LEN   = 'h52;

    typedef logic [1:0] lg_t;

    // Mask covering (1 << lg) low bytes of the bus word.
    function automatic logic [BUS_W-1:0] byte_mask(input lg_t lg);
        case (lg)
            2'd0:    return 32'h0000_00FF;
            2'd1:    return 32'h0000_FFFF;
            default: return 32'hFFFF_FFFF;
        endcase
    endfunction

    // Query table contents; entries not listed read as zero.
    function automatic logic [7:0] tbl_byte(
        input logic [6:0]  idx,
        input lg_t         bank_lg,
        input logic [7:0]  size_lg,
        input logic [15:0] blocks_m1,
        input logic [15:0] sect_hi
    );
        case (idx)
            7'h10: return 8'h51;
            7'h11: return 8'h52;
            7'h12: return 8'h59;
            7'h13: return 8'h01;
            7'h15: return 8'h31;
            7'h1B: return 8'h45;
            7'h1C: return 8'h55;
            7'h1F: return 8'h07;
            7'h20: return 8'h07;
            7'h21: return 8'h0A;
            7'h23: return 8'h04;
            7'h24: return 8'h04;
            7'h25: return 8'h04;
            7'h27: return size_lg;
            7'h28: return 8'h02;
            7'h2A: return (bank_lg == 2'd0) ? 8'h08 : 8'h0B;
            7'h2C: return 8'h01;
            7'h2D: return blocks_m1[7:0];
            7'h2E: return blocks_m1[15:8];
            7'h2F: return sect_hi[7:0];
            7'h30: return sect_hi[15:8];
            7'h31: return 8'h50;
            7'h32: return 8'h52;
            7'h33: return 8'h49;
            7'h34: return 8'h31;
            7'h35: return 8'h30;
            7'h3F: return 8'h01;
            default: return 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/qlr_index.sv
// Address to table index conversion for one slice.
// Assumes maxdev_lg >= dev_lg; a negative shift is clamped to zero.
module qlr_index #(
    parameter int ADDR_W = 16
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              flat_mode,
    input  qlr_pkg::lg_t      bank_lg,
    input  qlr_pkg::lg_t      dev_lg,
    input  qlr_pkg::lg_t      maxdev_lg,
    output logic [ADDR_W-1:0] idx
);
    logic signed [3:0] shift_s;

    // Shift amount from the three width codes, then the index itself.
    always_comb begin
        shift_s = $signed({2'b00, bank_lg}) + $signed({2'b00, maxdev_lg})
                - $signed({2'b00, dev_lg});
        if (flat_mode) begin
            idx = ADDR_W'(addr[7:0]) >> bank_lg;
        end else if (shift_s < 0) begin
            idx = addr;
        end else begin
            idx = addr >> shift_s[2:0];
        end
    end
endmodule

// File: rtl/qlr_slice.sv
// One bank-wide slice: table or identifier lookup, device-width fill,
// and copy across device lanes. Clock and reset serve the checks only.
module qlr_slice #(
    parameter int          ADDR_W    = 16,
    parameter logic [15:0] ID_A      = 16'h0000,
    parameter logic [15:0] ID_B      = 16'h0000,
    parameter logic [15:0] ID_C      = 16'h0000,
    parameter logic [15:0] ID_D      = 16'h0000,
    parameter logic [7:0]  SIZE_LG   = 8'd0,
    parameter logic [15:0] BLOCKS_M1 = 16'd0,
    parameter logic [15:0] SECT_HI   = 16'd0
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [ADDR_W-1:0]          addr,
    input  logic                       id_mode,
    input  logic                       flat_mode,
    input  qlr_pkg::lg_t               bank_lg,
    input  qlr_pkg::lg_t               dev_lg,
    input  qlr_pkg::lg_t               maxdev_lg,
    output logic [qlr_pkg::BUS_W-1:0]  slice_data
);
    import qlr_pkg::*;

    logic [ADDR_W-1:0] idx;
    logic [7:0]        q_byte;
    logic [BUS_W-1:0]  base;
    logic [BUS_W-1:0]  chunk;

    qlr_index #(.ADDR_W(ADDR_W)) index_i (
        .addr      (addr),
        .flat_mode (flat_mode),
        .bank_lg   (bank_lg),
        .dev_lg    (dev_lg),
        .maxdev_lg (maxdev_lg),
        .idx       (idx)
    );

    // Table byte with the out-of-range index forced to zero.
    always_comb begin
        if (idx >= ADDR_W'(TBL_LEN)) begin
            q_byte = 8'h00;
        end else begin
            q_byte = tbl_byte(idx[6:0], bank_lg, SIZE_LG, BLOCKS_M1, SECT_HI);
        end
    end

    // Per-device value before it is copied across the bank.
    always_comb begin
        if (id_mode) begin
            case (idx[7:0])
                8'd0:    base = {16'h0000, ID_A};
                8'd1:    base = {16'h0000, ID_B};
                default: base = '0;
            endcase
        end else if (dev_lg != maxdev_lg) begin
            base = (dev_lg == 2'd0) ? ({BUS_BYTES{q_byte}} & byte_mask(maxdev_lg)) : '0;
        end else begin
            base = {24'h000000, q_byte};
        end
        chunk = base & byte_mask(dev_lg);
    end

    // Lane copy across the bank, or the flat-mode result.
    always_comb begin
        slice_data = '0;
        if (flat_mode) begin
            if (id_mode) begin
                case (idx[7:0])
                    8'd0:    slice_data = {16'h0000, ID_A[7:0], ID_B[7:0]};
                    8'd1:    slice_data = {16'h0000, ID_C[7:0], ID_D[7:0]};
                    default: slice_data = '0;
                endcase
            end else begin
                slice_data = {24'h000000, q_byte};
            end
        end else begin
            if (dev_lg < bank_lg) begin
                for (int j = 0; j < BUS_BYTES; j++) begin
                    if ((j << dev_lg) < (1 << bank_lg)) begin
                        slice_data = slice_data | (chunk << (8 * (j << dev_lg)));
                    end
                end
            end else begin
                slice_data = base;
            end
            slice_data = slice_data & byte_mask(bank_lg);
        end
    end

    // R2: a query index past the table end yields an empty slice.
    p_oob_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!flat_mode && !id_mode && idx >= ADDR_W'(TBL_LEN)) |-> slice_data == '0);

    // R4: a width mismatch with a device wider than one byte yields zero.
    p_unsup_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!flat_mode && !id_mode && dev_lg != maxdev_lg && dev_lg != 2'd0)
        |-> slice_data == '0);

    // R6: identifier indices other than 0 and 1 yield zero.
    p_ident_far_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!flat_mode && id_mode && idx[7:0] > 8'd1) |-> slice_data == '0);
endmodule

// File: rtl/qlr_pack.sv
// Places bank-wide slices upward from bit 0 and trims to the access width.
// Assumes slice k was looked up k bank widths above the base address.
module qlr_pack #(
    parameter int SLICES = qlr_pkg::BUS_BYTES
) (
    input  logic [SLICES-1:0][qlr_pkg::BUS_W-1:0] slices,
    input  logic                                  flat_mode,
    input  qlr_pkg::lg_t                          bank_lg,
    input  qlr_pkg::lg_t                          acc_lg,
    output logic [qlr_pkg::BUS_W-1:0]             word
);
    import qlr_pkg::*;

    logic [BUS_W-1:0] joined;

    // Join the slices that fall inside the access, then trim.
    always_comb begin
        joined = '0;
        if (flat_mode) begin
            joined = slices[0];
        end else begin
            for (int k = 0; k < SLICES; k++) begin
                if ((k << bank_lg) < (1 << acc_lg)) begin
                    joined = joined | (slices[k] << (8 * (k << bank_lg)));
                end
            end
        end
        word = joined & byte_mask(acc_lg);
    end
endmodule

// File: rtl/qlr_lane_replicator.sv
// Top of the query response lane replicator: one lookup slice per bus
// byte, a packer, and a single output register loaded by the strobe.
// Assumes DEV_BLOCKS and SECTOR_BYTES are powers of two.
module qlr_lane_replicator #(
    parameter int          ADDR_W       = 16,
    parameter logic [15:0] ID_A         = 16'h0089,
    parameter logic [15:0] ID_B         = 16'h0018,
    parameter logic [15:0] ID_C         = 16'h0000,
    parameter logic [15:0] ID_D         = 16'h0000,
    parameter int          DEV_BLOCKS   = 64,
    parameter int          SECTOR_BYTES = 65536
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_stb,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [1:0]        acc_lg,
    input  logic              id_mode,
    input  logic              flat_mode,
    input  logic [1:0]        bank_lg,
    input  logic [1:0]        dev_lg,
    input  logic [1:0]        maxdev_lg,
    output logic [31:0]       rd_data,
    output logic              rd_valid
);
    import qlr_pkg::*;

    localparam int          SLICES    = BUS_BYTES;
    localparam logic [7:0]  SIZE_LG   = 8'($clog2(DEV_BLOCKS) + $clog2(SECTOR_BYTES));
    localparam logic [15:0] BLOCKS_M1 = 16'(DEV_BLOCKS - 1);
    localparam logic [15:0] SECT_HI   = 16'(SECTOR_BYTES >> 8);

    logic [SLICES-1:0][ADDR_W-1:0] slice_addr;
    logic [SLICES-1:0][BUS_W-1:0]  slice_data;
    logic [BUS_W-1:0]              word;

    for (genvar k = 0; k < SLICES; k++) begin : g_slice
        // Address of this slice, k bank widths above the base.
        always_comb slice_addr[k] = rd_addr + (ADDR_W'(k) << bank_lg);

        qlr_slice #(
            .ADDR_W    (ADDR_W),
            .ID_A      (ID_A),
            .ID_B      (ID_B),
            .ID_C      (ID_C),
            .ID_D      (ID_D),
            .SIZE_LG   (SIZE_LG),
            .BLOCKS_M1 (BLOCKS_M1),
            .SECT_HI   (SECT_HI)
        ) slice_i (
            .clk        (clk),
            .rst_n      (rst_n),
            .addr       (slice_addr[k]),
            .id_mode    (id_mode),
            .flat_mode  (flat_mode),
            .bank_lg    (bank_lg),
            .dev_lg     (dev_lg),
            .maxdev_lg  (maxdev_lg),
            .slice_data (slice_data[k])
        );
    end

    qlr_pack #(.SLICES(SLICES)) pack_i (
        .slices    (slice_data),
        .flat_mode (flat_mode),
        .bank_lg   (bank_lg),
        .acc_lg    (acc_lg),
        .word      (word)
    );

    // Output register: capture on strobe, valid one cycle later.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data  <= '0;
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= rd_stb;
            if (rd_stb) begin
                rd_data <= word;
            end
        end
    end

    // R10: a strobe is followed by valid.
    p_stb_valid_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stb |=> rd_valid);

    // R10: no strobe, no valid and no data change.
    p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_stb |=> (!rd_valid && $stable(rd_data)));

    // R9: a one-byte access leaves the upper bytes clear.
    p_narrow_upper_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && acc_lg == 2'd0) |=> rd_data[31:8] == 24'h0);
endmodule

// File: tb/qlr_lane_replicator_tb_top.sv
// Directed bench for the query response lane replicator.
module qlr_lane_replicator_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rd_stb = 1'b0;
    logic [15:0] rd_addr = '0;
    logic [1:0]  acc_lg = '0;
    logic        id_mode = 1'b0;
    logic        flat_mode = 1'b0;
    logic [1:0]  bank_lg = '0;
    logic [1:0]  dev_lg = '0;
    logic [1:0]  maxdev_lg = '0;
    logic [31:0] rd_data;
    logic        rd_valid;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    qlr_lane_replicator #(
        .ADDR_W(16), .ID_A(16'hA189), .ID_B(16'hB218),
        .ID_C(16'h00C3), .ID_D(16'h00D4),
        .DEV_BLOCKS(64), .SECTOR_BYTES(65536)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .rd_stb(rd_stb), .rd_addr(rd_addr),
        .acc_lg(acc_lg), .id_mode(id_mode), .flat_mode(flat_mode),
        .bank_lg(bank_lg), .dev_lg(dev_lg), .maxdev_lg(maxdev_lg),
        .rd_data(rd_data), .rd_valid(rd_valid)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_vec++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %08h expected %08h", req, got, exp);
        end
    endtask

    task automatic cfg(input bit flat, input logic [1:0] b, input logic [1:0] d, input logic [1:0] m);
        flat_mode = flat; bank_lg = b; dev_lg = d; maxdev_lg = m;
    endtask

    // Strobe one read and check data and valid one cycle later.
    task automatic rd(input string req, input logic [15:0] a, input logic [1:0] acc,
                      input bit idm, input logic [31:0] exp);
        @(negedge clk);
        rd_addr = a; acc_lg = acc; id_mode = idm; rd_stb = 1'b1;
        @(negedge clk);
        rd_stb = 1'b0;
        check(req, {31'd0, rd_valid}, 32'd1);
        check(req, rd_data, exp);
    endtask

    task automatic t_reset_r10();
        check("R10 reset valid", {31'd0, rd_valid}, 32'd0);
        check("R10 reset data", rd_data, 32'd0);
    endtask

    task automatic t_signature_r1_r3();
        cfg(0, 2'd0, 2'd0, 2'd0);
        rd("R3 Q", 16'h0010, 2'd0, 0, 32'h51);
        rd("R3 R", 16'h0011, 2'd0, 0, 32'h52);
        rd("R3 Y", 16'h0012, 2'd0, 0, 32'h59);
        rd("R3 code bank1", 16'h002A, 2'd0, 0, 32'h08);
        cfg(0, 2'd1, 2'd1, 2'd1);
        rd("R1 R3 code bank2", 16'h0054, 2'd1, 0, 32'h0000_000B);
    endtask

    task automatic t_lane_copy_r5();
        cfg(0, 2'd2, 2'd1, 2'd1);
        rd("R1 R5 bank4 dev2", 16'h0040, 2'd2, 0, 32'h0051_0051);
    endtask

    task automatic t_dev_fill_r4();
        cfg(0, 2'd1, 2'd0, 2'd1);
        rd("R4 dev1 max2", 16'h0044, 2'd1, 0, 32'h0000_5252);
        cfg(0, 2'd2, 2'd0, 2'd2);
        rd("R4 dev1 max4", 16'h0120, 2'd2, 0, 32'h5959_5959);
        cfg(0, 2'd2, 2'd1, 2'd2);
        rd("R4 unsupported", 16'h0080, 2'd2, 0, 32'h0);
    endtask

    task automatic t_range_r2();
        cfg(0, 2'd0, 2'd0, 2'd0);
        rd("R2 idx 0x52", 16'h0052, 2'd0, 0, 32'h0);
        rd("R2 idx 0x110", 16'h0110, 2'd0, 0, 32'h0);
    endtask

    task automatic t_ident_r6();
        cfg(0, 2'd1, 2'd1, 2'd1);
        rd("R6 idx0", 16'h0000, 2'd1, 1, 32'h0000_A189);
        rd("R6 idx1", 16'h0002, 2'd1, 1, 32'h0000_B218);
        rd("R6 idx2", 16'h0004, 2'd1, 1, 32'h0);
        cfg(0, 2'd2, 2'd0, 2'd0);
        rd("R6 R5 bank4 idx0", 16'h0000, 2'd2, 1, 32'h8989_8989);
        rd("R6 R5 bank4 idx1", 16'h0004, 2'd2, 1, 32'h1818_1818);
        cfg(0, 2'd0, 2'd0, 2'd0);
        rd("R6 low byte idx", 16'h0400, 2'd0, 1, 32'h89);
    endtask

    task automatic t_slices_r7();
        cfg(0, 2'd0, 2'd0, 2'd0);
        rd("R7 bank1 acc4", 16'h0010, 2'd2, 0, 32'h0159_5251);
        rd("R7 ident acc2", 16'h0000, 2'd1, 1, 32'h0000_1889);
        cfg(0, 2'd1, 2'd1, 2'd1);
        rd("R7 bank2 acc4", 16'h0020, 2'd2, 0, 32'h0052_0051);
    endtask

    task automatic t_flat_r8();
        cfg(1, 2'd1, 2'd0, 2'd0);
        rd("R8 ident idx0", 16'h0000, 2'd1, 1, 32'h0000_8918);
        rd("R8 ident idx1", 16'h0002, 2'd1, 1, 32'h0000_C3D4);
        rd("R8 ident idx2", 16'h0004, 2'd1, 1, 32'h0);
        cfg(1, 2'd2, 2'd0, 2'd0);
        rd("R8 query", 16'h0040, 2'd2, 0, 32'h51);
        rd("R8 low byte only", 16'h0140, 2'd2, 0, 32'h51);
    endtask

    task automatic t_trim_r9();
        cfg(0, 2'd2, 2'd0, 2'd0);
        rd("R9 acc1 of bank4", 16'h0000, 2'd0, 1, 32'h0000_0089);
        rd("R9 acc2 of bank4", 16'h0000, 2'd1, 1, 32'h0000_8989);
        cfg(1, 2'd0, 2'd0, 2'd0);
        rd("R9 flat acc1", 16'h0000, 2'd0, 1, 32'h0000_0018);
    endtask

    task automatic t_hold_r10();
        cfg(0, 2'd0, 2'd0, 2'd0);
        rd("R10 load", 16'h0011, 2'd0, 0, 32'h52);
        @(negedge clk);
        check("R10 valid drops", {31'd0, rd_valid}, 32'd0);
        rd_addr = 16'h0012;
        @(negedge clk);
        @(negedge clk);
        check("R10 data held", rd_data, 32'h52);
        check("R10 valid low", {31'd0, rd_valid}, 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset_r10();
        rst_n = 1'b1;
        t_signature_r1_r3();
        t_lane_copy_r5();
        t_dev_fill_r4();
        t_range_r2();
        t_ident_r6();
        t_slices_r7();
        t_flat_r8();
        t_trim_r9();
        t_hold_r10();
        if (!done) begin
            done = 1'b1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            done = 1'b1;
            n_vec++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule